// File: doc/BRIEF.md
# Seven-Slot Serial Pixel Deserializer

This block sits behind the line receivers of a flat-panel video link. Each cycle of `clk` delivers one slot sample from every data lane and one sample from the clock lane. Seven slots on each lane make up one pixel. The block watches the clock lane for the high-high-low-low-low-high-high pattern that marks a complete group. It then reassembles the pixel from the seven-bit words it has shifted in: 8-bit red, green and blue, plus the horizontal sync, vertical sync and data-enable controls.

Three packing layouts are supported. One is an 18-bit layout that uses lanes 0 to 2. The other two are 24-bit layouts that use all four lanes and differ in where the extra colour bits go. A mirror input handles links that send the slots of each group in reverse order. The layout and mirror inputs are static configuration and match the settings of the far-end transmitter.

A lock tracker checks every seventh cycle that the boundary is still where it was. It declares lock after four good groups in a row and gives it up after two bad ones in a row. Pixels are only presented while the link is locked.

Top module: `lvds_pix_deser`

## Requirements
- R1: A group counts as complete when the last seven clock-lane samples, earliest first, are 1,1,0,0,0,1,1. The pixel decoded from it appears on the outputs one cycle after the edge that captured its seventh slot.
- R2: After reset `locked_o` is 0. It rises on the fourth consecutive complete group, where each group after the first ends exactly seven cycles after the one before.
- R3: While locked, one group whose clock-lane samples do not match leaves `locked_o` at 1 and produces no pixel. Two such groups in a row clear `locked_o`, and lock must then be acquired again as in R2.
- R4: `pix_valid_o` is a one-cycle pulse for each complete group decoded while `locked_o` is 1. It never pulses while unlocked.
- R5: With `map_sel_i`=00 (or the reserved value 11), only lanes 0 to 2 are used. Slots 1..6 of lane 0 carry red[7:2] from MSB down. Lane 1 slots 2..6 carry green[7:3] and lane 0 slot 0 carries green[2]. Lane 2 slots 3..6 carry blue[7:4] and lane 1 slots 0,1 carry blue[3:2]. Bits [1:0] of every colour are 0 and lane 3 is ignored.
- R6: With `map_sel_i`=01, lanes 0 to 2 carry colour bits [7:2] as in R5. Lane 3 slots 1,2 carry blue[1:0], slots 3,4 carry green[1:0] and slots 5,6 carry red[1:0].
- R7: With `map_sel_i`=10, lanes 0 to 2 carry colour bits [5:0] in the R5 positions. Lane 3 slots 1,2 carry blue[7:6], slots 3,4 carry green[7:6] and slots 5,6 carry red[7:6].
- R8: Lane 2 slot 2 drives `hsync_o`, slot 1 drives `vsync_o` and slot 0 drives `de_o`.
- R9: With `mirror_i`=1, slot 6 of each data lane arrives first and slot 0 arrives last. The clock lane is not reordered.
- R10: `ctl_err_o` becomes 1 when a pixel is presented in a 24-bit layout (01 or 10) and lane 3 slot 0 of that group was 1. It then stays 1 until reset. In the 18-bit layout it never rises.
- R11: Synchronous active-low reset clears all outputs to 0.
- R12: Colour and control outputs hold their value between pulses of `pix_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock, one slot per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_clk_i | input | 1 | Clock-lane slot sample |
| lane_dat_i | input | 4 | Data-lane slot samples, bit n is lane n |
| map_sel_i | input | 2 | Packing layout: 00 18-bit, 01 24-bit low extras, 10 24-bit high extras |
| mirror_i | input | 1 | Slots of each group arrive 6 down to 0 |
| red_o | output | 8 | Red component |
| green_o | output | 8 | Green component |
| blue_o | output | 8 | Blue component |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_valid_o | output | 1 | One-cycle strobe per presented pixel |
| locked_o | output | 1 | Group boundary is locked |
| ctl_err_o | output | 1 | Sticky: nonzero reserved control slot seen |

## Verification
The assertions assume that `map_sel_i` and `mirror_i` are steady around each decode edge. The layout checks and the sticky-error check compare the presented pixel with the layout sampled at the decode edge. The bench therefore changes these inputs only on the falling edge after a group has been decoded, while the next group's second slot is being driven. Clock-lane samples come either as the exact boundary pattern or as a constant-high run for a deliberately broken group. Each group starts exactly seven cycles after the previous one.

// File: rtl/lvds_pix_deser_pkg.sv
// Package: shared constants and types for the seven-slot pixel deserializer.
// Assumes a fixed seven-slot group and four physical data lanes.
package lvds_pix_deser_pkg;

    localparam int SLOTS     = 7;
    localparam int LANES     = 4;
    localparam int COLOR_W   = 8;
    localparam int CORE_W    = 6;
    localparam int EXTRA_W   = COLOR_W - CORE_W;

    // Clock-lane samples of one group, slot 0 in the MSB.
    localparam logic [SLOTS-1:0] BOUNDARY_PAT = 7'b1100011;

    typedef enum logic [1:0] {
        MAP_18   = 2'b00,
        MAP_24LO = 2'b01,
        MAP_24HI = 2'b10,
        MAP_RSVD = 2'b11
    } map_e;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
        logic               hs;
        logic               vs;
        logic               de;
    } pixel_t;

    typedef logic [LANES-1:0][SLOTS-1:0] slot_arr_t;

endpackage

// File: rtl/lvds_slot_capture.sv
// Module: shifts each data lane into a seven-bit word and presents it
// indexed by transmit slot number, undoing mirrored order when asked.
// Assumes one new slot sample per lane on every clock edge.
module lvds_slot_capture #(
    parameter int LANES = 4,
    parameter int SLOTS = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            lane_i,
    input  logic                        mirror_i,
    output logic [LANES-1:0][SLOTS-1:0] slot_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOTS-1:0] shreg;

        // Shift the newest sample in at the LSB; oldest sits at the MSB.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= '0;
            end else begin
                shreg <= {shreg[SLOTS-2:0], lane_i[l]};
            end
        end

        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            // Map arrival position to transmit slot number.
            assign slot_o[l][k] = mirror_i ? shreg[k] : shreg[SLOTS-1-k];
        end
    end

endmodule

// File: rtl/lvds_group_align.sv
// Module: finds the group boundary on the clock lane and tracks lock.
// Hunting: any pattern match realigns the seven-cycle phase.
// Locked: only the phase checkpoint is evaluated and misses are counted.
// Assumes one clock-lane sample per edge.
module lvds_group_align #(
    parameter int               SLOTS     = 7,
    parameter logic [SLOTS-1:0] PATTERN   = 7'b1100011,
    parameter int               LOCK_GOOD = 4,
    parameter int               LOCK_BAD  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lane_clk_i,
    output logic accept_o,
    output logic locked_o
);

    localparam int PW = $clog2(SLOTS);
    localparam int GW = $clog2(LOCK_GOOD + 1);
    localparam int BW = $clog2(LOCK_BAD + 1);
    localparam logic [PW-1:0] LAST_PH = PW'(SLOTS - 1);

    logic [SLOTS-1:0] clk_sh;
    logic [PW-1:0]    phase;
    logic [GW-1:0]    good_cnt;
    logic [BW-1:0]    bad_cnt;
    logic             locked_q;
    logic             match;
    logic             checkpoint;

    assign match      = (clk_sh == PATTERN);
    assign checkpoint = (phase == LAST_PH);
    assign accept_o   = locked_q && checkpoint && match;
    assign locked_o   = locked_q;

    // Clock-lane history, oldest sample in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sh <= '0;
        end else begin
            clk_sh <= {clk_sh[SLOTS-2:0], lane_clk_i};
        end
    end

    // Phase counter, lock acquisition and lock loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            good_cnt <= '0;
            bad_cnt  <= '0;
            locked_q <= 1'b0;
        end else begin
            phase <= checkpoint ? '0 : phase + 1'b1;
            if (!locked_q) begin
                if (match) begin
                    if (checkpoint) begin
                        if (good_cnt == GW'(LOCK_GOOD - 1)) begin
                            locked_q <= 1'b1;
                            good_cnt <= '0;
                            bad_cnt  <= '0;
                        end else begin
                            good_cnt <= good_cnt + 1'b1;
                        end
                    end else begin
                        phase    <= '0;
                        good_cnt <= GW'(1);
                    end
                end else if (checkpoint) begin
                    good_cnt <= '0;
                end
            end else if (checkpoint) begin
                if (match) begin
                    bad_cnt <= '0;
                end else if (bad_cnt == BW'(LOCK_BAD - 1)) begin
                    locked_q <= 1'b0;
                    bad_cnt  <= '0;
                    good_cnt <= '0;
                end else begin
                    bad_cnt <= bad_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lvds_pixel_unmap.sv
// Module: combinational inverse of the three packing layouts.
// Assumes slot_i is indexed [lane][transmit slot] with mirroring removed.
module lvds_pixel_unmap
    import lvds_pix_deser_pkg::*;
(
    input  slot_arr_t map_slots_i,
    input  map_e      map_i,
    output pixel_t    pix_o,
    output logic      ctl3_bad_o
);

    logic [CORE_W-1:0]  r_core, g_core, b_core;
    logic [EXTRA_W-1:0] r_ext, g_ext, b_ext;
    logic               wide;

    // Pull the six-bit core fields and controls out of lanes 0 to 2.
    always_comb begin
        r_core = {map_slots_i[0][1], map_slots_i[0][2], map_slots_i[0][3],
                  map_slots_i[0][4], map_slots_i[0][5], map_slots_i[0][6]};
        g_core = {map_slots_i[1][2], map_slots_i[1][3], map_slots_i[1][4],
                  map_slots_i[1][5], map_slots_i[1][6], map_slots_i[0][0]};
        b_core = {map_slots_i[2][3], map_slots_i[2][4], map_slots_i[2][5],
                  map_slots_i[2][6], map_slots_i[1][0], map_slots_i[1][1]};
    end

    // Pull the two-bit extension fields out of lane 3.
    always_comb begin
        b_ext = {map_slots_i[3][1], map_slots_i[3][2]};
        g_ext = {map_slots_i[3][3], map_slots_i[3][4]};
        r_ext = {map_slots_i[3][5], map_slots_i[3][6]};
    end

    // Place core and extension fields according to the layout.
    always_comb begin
        wide = 1'b0;
        unique case (map_i)
            MAP_24LO: begin
                wide        = 1'b1;
                pix_o.red   = {r_core, r_ext};
                pix_o.green = {g_core, g_ext};
                pix_o.blue  = {b_core, b_ext};
            end
            MAP_24HI: begin
                wide        = 1'b1;
                pix_o.red   = {r_ext, r_core};
                pix_o.green = {g_ext, g_core};
                pix_o.blue  = {b_ext, b_core};
            end
            default: begin
                pix_o.red   = {r_core, {EXTRA_W{1'b0}}};
                pix_o.green = {g_core, {EXTRA_W{1'b0}}};
                pix_o.blue  = {b_core, {EXTRA_W{1'b0}}};
            end
        endcase
        pix_o.hs   = map_slots_i[2][2];
        pix_o.vs   = map_slots_i[2][1];
        pix_o.de   = map_slots_i[2][0];
        ctl3_bad_o = wide && map_slots_i[3][0];
    end

endmodule

// File: rtl/lvds_pix_deser.sv
// Module: top of the seven-slot pixel deserializer. Captures slots, aligns
// to the group boundary, unmaps the layout and registers the pixel.
// Assumes map_sel_i and mirror_i are static across each decode edge.
module lvds_pix_deser
    import lvds_pix_deser_pkg::*;
#(
    parameter int LOCK_GOOD = 4,
    parameter int LOCK_BAD  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lane_clk_i,
    input  logic [LANES-1:0]   lane_dat_i,
    input  logic [1:0]         map_sel_i,
    input  logic               mirror_i,
    output logic [COLOR_W-1:0] red_o,
    output logic [COLOR_W-1:0] green_o,
    output logic [COLOR_W-1:0] blue_o,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic               pix_valid_o,
    output logic               locked_o,
    output logic               ctl_err_o
);

    slot_arr_t slots;
    pixel_t    pix_d, pix_q;
    logic      accept;
    logic      ctl3_bad;
    logic      valid_q;
    logic      err_q;

    lvds_slot_capture #(.LANES(LANES), .SLOTS(SLOTS)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_i   (lane_dat_i),
        .mirror_i (mirror_i),
        .slot_o   (slots)
    );

    lvds_group_align #(
        .SLOTS     (SLOTS),
        .PATTERN   (BOUNDARY_PAT),
        .LOCK_GOOD (LOCK_GOOD),
        .LOCK_BAD  (LOCK_BAD)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_clk_i (lane_clk_i),
        .accept_o   (accept),
        .locked_o   (locked_o)
    );

    lvds_pixel_unmap u_unmap (
        .map_slots_i (slots),
        .map_i       (map_e'(map_sel_i)),
        .pix_o       (pix_d),
        .ctl3_bad_o  (ctl3_bad)
    );

    // Register the accepted pixel, its strobe and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                pix_q <= pix_d;
            end
            if (accept && ctl3_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    assign red_o       = pix_q.red;
    assign green_o     = pix_q.green;
    assign blue_o      = pix_q.blue;
    assign hsync_o     = pix_q.hs;
    assign vsync_o     = pix_q.vs;
    assign de_o        = pix_q.de;
    assign pix_valid_o = valid_q;
    assign ctl_err_o   = err_q;

endmodule

// File: rtl/lvds_pix_deser_chk.sv
// Module: checker bound to lvds_pix_deser; observes ports only.
// Assumes layout inputs are steady around each decode edge.
module lvds_pix_deser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] map_sel_i,
    input logic [7:0] red_o,
    input logic [7:0] green_o,
    input logic [7:0] blue_o,
    input logic       hsync_o,
    input logic       vsync_o,
    input logic       de_o,
    input logic       pix_valid_o,
    input logic       locked_o,
    input logic       ctl_err_o
);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |=> !pix_valid_o);

    // R4
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_o |-> locked_o);

    // R12
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_o |-> $stable({red_o, green_o, blue_o, hsync_o, vsync_o, de_o}));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err_o |=> ctl_err_o);

    // R10
    err_wide_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_err_o) |-> ($past(map_sel_i) == 2'b01 || $past(map_sel_i) == 2'b10));

    // R5
    narrow_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && ($past(map_sel_i) == 2'b00 || $past(map_sel_i) == 2'b11))
        |-> (red_o[1:0] == 2'b00 && green_o[1:0] == 2'b00 && blue_o[1:0] == 2'b00));

endmodule

bind lvds_pix_deser lvds_pix_deser_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_sel_i   (map_sel_i),
    .red_o       (red_o),
    .green_o     (green_o),
    .blue_o      (blue_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .de_o        (de_o),
    .pix_valid_o (pix_valid_o),
    .locked_o    (locked_o),
    .ctl_err_o   (ctl_err_o)
);

// File: tb/lvds_pix_deser_bench.sv
`timescale 1ns/1ps
module lvds_pix_deser_bench;

    typedef struct packed {
        logic [1:0] mode;
        logic       mir;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic       hs;
        logic       vs;
        logic       de;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{2'b01, 1'b0, 8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1},
        '{2'b01, 1'b0, 8'h5A, 8'hC3, 8'h0F, 1'b0, 1'b1, 1'b0},
        '{2'b10, 1'b0, 8'h81, 8'h42, 8'h24, 1'b1, 1'b1, 1'b1},
        '{2'b10, 1'b0, 8'hFE, 8'h01, 8'h7F, 1'b0, 1'b0, 1'b1},
        '{2'b00, 1'b0, 8'hFF, 8'hAB, 8'h57, 1'b1, 1'b0, 1'b0},
        '{2'b11, 1'b0, 8'h9C, 8'h63, 8'hE4, 1'b0, 1'b1, 1'b1},
        '{2'b01, 1'b1, 8'hC8, 8'h1D, 8'hB6, 1'b1, 1'b0, 1'b1},
        '{2'b10, 1'b1, 8'h37, 8'hE2, 8'h49, 1'b0, 1'b1, 1'b0}
    };
    localparam logic [6:0] PAT = 7'b1100011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lane_clk_i = 1'b0;
    logic [3:0] lane_dat_i = '0;
    logic [1:0] map_sel_i = 2'b01;
    logic       mirror_i = 1'b0;
    logic [7:0] red_o, green_o, blue_o;
    logic       hsync_o, vsync_o, de_o, pix_valid_o, locked_o, ctl_err_o;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    // expectation of the last group sent
    logic       e_pv = 1'b0, e_err = 1'b0, e_hs = 1'b0, e_vs = 1'b0, e_de = 1'b0;
    logic [7:0] e_r = '0, e_g = '0, e_b = '0;
    string      e_tag = "R2";
    bit         e_live = 1'b0;
    // captured outputs
    logic       c_pv, c_pv2, c_lock, c_err, c_hs, c_vs, c_de;
    logic [7:0] c_r, c_g, c_b;

    always #2.5 clk = ~clk;

    lvds_pix_deser u_lvds_pix_deser (
        .clk(clk), .rst_n(rst_n), .lane_clk_i(lane_clk_i), .lane_dat_i(lane_dat_i),
        .map_sel_i(map_sel_i), .mirror_i(mirror_i), .red_o(red_o), .green_o(green_o),
        .blue_o(blue_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pix_valid_o(pix_valid_o), .locked_o(locked_o), .ctl_err_o(ctl_err_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Transmit-side packing written from the layout requirements R5..R8.
    function automatic logic [3:0][6:0] pack(input logic [1:0] mode, input logic [7:0] r,
            input logic [7:0] g, input logic [7:0] b, input logic hs, input logic vs,
            input logic de, input logic ctl3, input logic [5:0] junk);
        logic [3:0][6:0] s;
        logic [5:0] rc, gc, bc;
        logic [1:0] rx, gx, bx;
        if (mode == 2'b10) begin
            rc = r[5:0]; gc = g[5:0]; bc = b[5:0];
            rx = r[7:6]; gx = g[7:6]; bx = b[7:6];
        end else begin
            rc = r[7:2]; gc = g[7:2]; bc = b[7:2];
            rx = r[1:0]; gx = g[1:0]; bx = b[1:0];
        end
        if (mode == 2'b00 || mode == 2'b11) {rx, gx, bx} = junk;
        for (int k = 1; k < 7; k++) s[0][k] = rc[6-k];
        s[0][0] = gc[0];
        for (int k = 2; k < 7; k++) s[1][k] = gc[7-k];
        s[1][0] = bc[1]; s[1][1] = bc[0];
        for (int k = 3; k < 7; k++) s[2][k] = bc[8-k];
        s[2][0] = de; s[2][1] = vs; s[2][2] = hs;
        s[3][0] = ctl3;
        s[3][1] = bx[1]; s[3][2] = bx[0];
        s[3][3] = gx[1]; s[3][4] = gx[0];
        s[3][5] = rx[1]; s[3][6] = rx[0];
        return s;
    endfunction

    // Send one seven-slot group; on its second slot, check the previous group.
    task automatic send(input logic [1:0] mode, input logic mir, input logic [7:0] r,
            input logic [7:0] g, input logic [7:0] b, input logic hs, input logic vs,
            input logic de, input logic ctl3, input logic [5:0] junk, input logic bad,
            input logic exp_pv, input string tag);
        logic [3:0][6:0] s;
        bit narrow;
        s = pack(mode, r, g, b, hs, vs, de, ctl3, junk);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            if (k == 1) begin
                c_pv = pix_valid_o; c_lock = locked_o; c_err = ctl_err_o;
                c_r = red_o; c_g = green_o; c_b = blue_o;
                c_hs = hsync_o; c_vs = vsync_o; c_de = de_o;
                map_sel_i = mode;
                mirror_i  = mir;
            end
            if (k == 2) c_pv2 = pix_valid_o;
            for (int l = 0; l < 4; l++) lane_dat_i[l] = s[l][mir ? 6 - k : k];
            lane_clk_i = bad ? 1'b1 : PAT[6-k];
        end
        if (e_live) begin
            chk({e_tag, " valid"}, c_pv, e_pv);
            if (e_pv) chk("R4 pulse", c_pv2, 0);
            chk({e_tag, " red"}, c_r, e_r);
            chk({e_tag, " green"}, c_g, e_g);
            chk({e_tag, " blue"}, c_b, e_b);
            chk({e_tag, " R8 ctl"}, {c_hs, c_vs, c_de}, {e_hs, e_vs, e_de});
            chk("R10 err", c_err, e_err);
        end
        e_live = 1'b1;
        e_tag  = tag;
        e_pv   = exp_pv;
        if (exp_pv) begin
            narrow = (mode == 2'b00 || mode == 2'b11);
            e_r = narrow ? {r[7:2], 2'b00} : r;
            e_g = narrow ? {g[7:2], 2'b00} : g;
            e_b = narrow ? {b[7:2], 2'b00} : b;
            e_hs = hs; e_vs = vs; e_de = de;
            if (!narrow && ctl3) e_err = 1'b1;
        end
    endtask

    task automatic idle(input logic exp_pv, input string tag);
        send(2'b01, 1'b0, 8'h12, 8'h34, 8'h56, 1'b0, 1'b0, 1'b1, 1'b0, 6'h0, 1'b0, exp_pv, tag);
    endtask

    task automatic broken(input string tag);
        send(2'b01, 1'b0, 8'hEE, 8'hDD, 8'hCC, 1'b1, 1'b1, 1'b1, 1'b0, 6'h0, 1'b1, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lane_clk_i = 1'b0;
        lane_dat_i = '0;
        repeat (5) @(negedge clk);
        chk("R11 reset red", red_o, 0);
        chk("R11 reset grn", green_o, 0);
        chk("R11 reset blu", blue_o, 0);
        chk("R11 reset ctl", {hsync_o, vsync_o, de_o}, 0);
        chk("R11 reset valid", pix_valid_o, 0);
        chk("R2 reset lock", locked_o, 0);
        chk("R11 reset err", ctl_err_o, 0);
        rst_n = 1'b1;
        e_live = 1'b0; e_err = 1'b0;
        e_r = '0; e_g = '0; e_b = '0; e_hs = 0; e_vs = 0; e_de = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1, R2: four groups to lock, none presented
        idle(1'b0, "R2");
        idle(1'b0, "R2");
        idle(1'b0, "R2");
        chk("R2 not yet locked", c_lock, 0);
        idle(1'b0, "R2");
        chk("R2 not yet locked", c_lock, 0);
        for (int i = 0; i < NVEC; i++) begin
            send(VECS[i].mode, VECS[i].mir, VECS[i].r, VECS[i].g, VECS[i].b,
                 VECS[i].hs, VECS[i].vs, VECS[i].de, 1'b0, 6'h2A, 1'b0, 1'b1,
                 VECS[i].mir ? "R9" : (VECS[i].mode == 2'b01 ? "R6" :
                                      (VECS[i].mode == 2'b10 ? "R7" : "R5")));
            if (i == 0) chk("R2 locked on fourth", c_lock, 1);
        end
        // R3: one broken group keeps lock, no pixel, outputs held (R12)
        broken("R3");
        idle(1'b1, "R1");
        chk("R3 single miss keeps lock", c_lock, 1);
        // R3: two broken groups drop lock
        broken("R3");
        broken("R3");
        chk("R3 first miss", c_lock, 1);
        idle(1'b0, "R3");
        chk("R3 lock lost", c_lock, 0);
        idle(1'b0, "R2");
        idle(1'b0, "R2");
        idle(1'b0, "R2");
        // R5, R10: 18-bit layout with lane 3 data and CTL3 set is ignored
        send(2'b00, 1'b0, 8'hC4, 8'h93, 8'h6E, 1'b1, 1'b1, 1'b0, 1'b1, 6'h3F, 1'b0, 1'b1, "R5");
        chk("R2 relocked", c_lock, 1);
        // R10: CTL3 set in a 24-bit layout flags the error
        send(2'b10, 1'b0, 8'h11, 8'h22, 8'h33, 1'b0, 1'b0, 1'b1, 1'b1, 6'h0, 1'b0, 1'b1, "R10");
        idle(1'b1, "R10");
        idle(1'b1, "R10");
        chk("R10 sticky", c_err, 1);
        do_reset();
        chk("R10 cleared by reset", ctl_err_o, 0);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule